// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a circular buffer of 32 sixteen-bit words placed between a host register port and a card-side byte engine. It keeps a head pointer, a tail pointer and a fill count. After every cycle it compares the fill count against two programmable watermarks: a high mark for the receive direction and a low mark for the transmit direction. A watermark only counts while the transfer runs in its own direction.

When a watermark is crossed, the crossing is routed to one of two places. If DMA is enabled for that direction, it drives the DMA request line. Otherwise it sets a polled status flag. Software picks the route and the two watermarks by writing a single 16-bit configuration word. The flags and request lines are level signals that are re-evaluated each cycle from the fill count after that cycle's update.

Top module: `tfifo_dma`

## Requirements
- R1: After reset the count is 0, `empty_o` is 1, `full_o` is 0, all four request/flag outputs are 0, and `cfg_o` reads 0x1F00 (high mark 31, low mark 0, both DMA enables off).
- R2: Accepted words come out in the order they were pushed. Head and tail pointers wrap modulo 32, and `pop_data_o` always presents the word at the head.
- R3: A push while the count is 32 and no pop is accepted is dropped: the count stays 32 and the stored words are unchanged.
- R4: A pop while the count is 0 presents the word stored at the head and moves no pointer, so the count stays 0.
- R5: A push and a pop in the same cycle leave the count unchanged when 0 < count < 32. At count 32 only the pop is taken (count 31). At count 0 only the push is taken (count 1).
- R6: With `dir_rx_i` = 1 and count > high mark: `rx_dma_req_o` = 1 if the receive DMA enable is set, otherwise `af_flag_o` = 1. Both are never 1 together.
- R7: With `dir_rx_i` = 0 and count < low mark: `tx_dma_req_o` = 1 if the transmit DMA enable is set, otherwise `ae_flag_o` = 1. Both are never 1 together.
- R8: When a direction's condition is false, including whenever the transfer runs the other way, that direction's request line and flag are both 0.
- R9: With `xfer_active_i` = 0 and count 0, all four request/flag outputs are 0. With `xfer_active_i` = 0 and a non-empty buffer, R6 and R7 still apply.
- R10: Configuration word layout: bit 15 is the receive DMA enable, bits 12:8 the high mark, bit 7 the transmit DMA enable, bits 4:0 the low mark. Bits 14:13 and 6:5 are not stored and read back as 0 on `cfg_o`.
- R11: Requests and flags reflect the count, configuration, direction and active inputs of the same edge: after the edge that accepts a push, a pop or a configuration write, they already match the new state.
- R12: Writing the configuration with a DMA enable set clears that direction's flag at the next edge and raises the request line instead, if the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write word |
| cfg_o | output | 16 | Configuration readback |
| xfer_active_i | input | 1 | A data transfer is in progress |
| dir_rx_i | input | 1 | Transfer direction: 1 receive, 0 transmit |
| push_i | input | 1 | Push one word |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop the head word |
| pop_data_o | output | 16 | Word at the head |
| count_o | output | 6 | Fill count, 0 to 32 |
| empty_o | output | 1 | Count is 0 |
| full_o | output | 1 | Count is 32 |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| af_flag_o | output | 1 | High-mark status flag (receive, no DMA) |
| ae_flag_o | output | 1 | Low-mark status flag (transmit, no DMA) |

## Verification
The embedded properties assume that `push_i`, `pop_i`, `dir_rx_i` and `xfer_active_i` carry known values at every sampled edge. They also assume that direction and active status are ordinary level inputs, which the evaluator samples on the same edge as the count. The stimulus drives every input on the falling clock edge and returns strobes to zero after each step. Direction and active status change only between steps, and a quiet cycle follows each change so the flags are re-evaluated before any check. A reference queue in the bench, with its own wrap-around index, predicts the head word, the count and the four threshold outputs.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int unsigned LVL_W     = 5;
  localparam int unsigned CFG_W     = 16;
  localparam int unsigned RX_EN_BIT = 15;
  localparam int unsigned AF_LSB    = 8;
  localparam int unsigned TX_EN_BIT = 7;
  localparam int unsigned AE_LSB    = 0;

  localparam logic [LVL_W-1:0] AF_RST = '1;
  localparam logic [LVL_W-1:0] AE_RST = '0;

  typedef struct packed {
    logic             rx_en;
    logic [LVL_W-1:0] af;
    logic             tx_en;
    logic [LVL_W-1:0] ae;
  } cfg_t;

  localparam cfg_t CFG_RST = '{rx_en: 1'b0, af: AF_RST, tx_en: 1'b0, ae: AE_RST};
endpackage

// File: rtl/tfifo_cfg.sv
module tfifo_cfg
  import tfifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_q_o,
  output cfg_t             cfg_d_o,
  output logic [CFG_W-1:0] rdata_o
);
  cfg_t cfg_q, cfg_d;
  logic unused_wbits;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d.rx_en = wdata_i[RX_EN_BIT];
      cfg_d.af    = wdata_i[AF_LSB +: LVL_W];
      cfg_d.tx_en = wdata_i[TX_EN_BIT];
      cfg_d.ae    = wdata_i[AE_LSB +: LVL_W];
    end
  end

  assign unused_wbits = ^{wdata_i[14:13], wdata_i[6:5]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[RX_EN_BIT]           = cfg_q.rx_en;
    rdata_o[AF_LSB +: LVL_W]     = cfg_q.af;
    rdata_o[TX_EN_BIT]           = cfg_q.tx_en;
    rdata_o[AE_LSB +: LVL_W]     = cfg_q.ae;
  end

  assign cfg_q_o = cfg_q;
  assign cfg_d_o = cfg_d;

  // R10: a write lands in the register on the next edge
  p_cfg_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[RX_EN_BIT] == $past(wdata_i[RX_EN_BIT]) &&
              rdata_o[AF_LSB +: LVL_W] == $past(wdata_i[AF_LSB +: LVL_W])));
endmodule

// File: rtl/tfifo_ring.sv
module tfifo_ring #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CNT_W-1:0] count_q_o,
  output logic [CNT_W-1:0] count_d_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q, count_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push_i && (count_q != CNT_W'(DEPTH));
  assign pop_ok  = pop_i  && (count_q != '0);

  always_comb begin
    count_d = count_q;
    if (push_ok && !pop_ok) count_d = count_q + 1'b1;
    if (pop_ok && !push_ok) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      count_q <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (push_ok && wr_ptr == PTR_W'(i)) mem[i] <= push_data_i;
    end
  end

  assign pop_data_o = mem[rd_ptr];
  assign count_q_o  = count_q;
  assign count_d_o  = count_d;

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_W'(DEPTH) && push_i && !pop_i) |=> (count_q == CNT_W'(DEPTH) && $stable(wr_ptr)));

  p_empty_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && pop_i && !push_i) |=> (count_q == '0 && $stable(rd_ptr)));

  p_pair_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && count_q != '0 && count_q != CNT_W'(DEPTH)) |=> $stable(count_q));
endmodule

// File: rtl/tfifo_level.sv
module tfifo_level
  import tfifo_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  cfg_t             cfg_i,
  input  logic             dir_rx_i,
  input  logic             active_i,
  output logic             rx_req_o,
  output logic             af_flag_o,
  output logic             tx_req_o,
  output logic             ae_flag_o
);
  logic idle, rx_hit, tx_hit;
  logic rx_req_d, af_d, tx_req_d, ae_d;
  logic rx_req_q, af_q, tx_req_q, ae_q;

  assign idle   = !active_i && (count_i == '0);
  assign rx_hit = dir_rx_i  && (count_i > CNT_W'(cfg_i.af));
  assign tx_hit = !dir_rx_i && (count_i < CNT_W'(cfg_i.ae));

  always_comb begin
    rx_req_d = 1'b0;
    af_d     = 1'b0;
    tx_req_d = 1'b0;
    ae_d     = 1'b0;
    if (!idle) begin
      if (rx_hit) begin
        rx_req_d = cfg_i.rx_en;
        af_d     = !cfg_i.rx_en;
      end
      if (tx_hit) begin
        tx_req_d = cfg_i.tx_en;
        ae_d     = !cfg_i.tx_en;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_req_q <= 1'b0;
      af_q     <= 1'b0;
      tx_req_q <= 1'b0;
      ae_q     <= 1'b0;
    end else begin
      rx_req_q <= rx_req_d;
      af_q     <= af_d;
      tx_req_q <= tx_req_d;
      ae_q     <= ae_d;
    end
  end

  assign rx_req_o  = rx_req_q;
  assign af_flag_o = af_q;
  assign tx_req_o  = tx_req_q;
  assign ae_flag_o = ae_q;

  p_rx_route_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_req_q && af_q));

  p_tx_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_req_q && ae_q));

  p_rx_dir_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_rx_i |=> (!rx_req_q && !af_q));

  p_tx_dir_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_rx_i |=> (!tx_req_q && !ae_q));

  p_idle_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && count_i == '0) |=> $onehot0(0) && !(rx_req_q || af_q || tx_req_q || ae_q));

  p_dma_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.rx_en) |=> !af_q);
endmodule

// File: rtl/tfifo_dma.sv
module tfifo_dma
  import tfifo_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  input  logic             xfer_active_i,
  input  logic             dir_rx_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             rx_dma_req_o,
  output logic             tx_dma_req_o,
  output logic             af_flag_o,
  output logic             ae_flag_o
);
  cfg_t             cfg_q, cfg_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             unused_cfg_q;

  tfifo_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_q_o (cfg_q),
    .cfg_d_o (cfg_d),
    .rdata_o (cfg_o)
  );

  assign unused_cfg_q = ^cfg_q;

  tfifo_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .count_q_o   (count_q),
    .count_d_o   (count_d)
  );

  // evaluate against next-state values so flags line up with count_o
  tfifo_level #(.CNT_W(CNT_W)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count_d),
    .cfg_i     (cfg_d),
    .dir_rx_i  (dir_rx_i),
    .active_i  (xfer_active_i),
    .rx_req_o  (rx_dma_req_o),
    .af_flag_o (af_flag_o),
    .tx_req_o  (tx_dma_req_o),
    .ae_flag_o (ae_flag_o)
  );

  assign count_o = count_q;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));

  p_flags_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (count_q == '0));

  p_edge_align_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rx_i && xfer_active_i && !cfg_d.rx_en && count_d > CNT_W'(cfg_d.af)) |=> af_flag_o);
endmodule

// File: tb/tfifo_dma_bench.sv
`timescale 1ns/1ps
module tfifo_dma_bench;
  localparam real CLK_HALF = 2.5;
  localparam int  NVEC = 16;

  // {cfg[15:0], dir_rx, active, count[5:0], {rx_req, af, tx_req, ae}}
  localparam logic [27:0] VECS [NVEC] = '{
    {16'h0A00, 1'b1, 1'b1, 6'd11, 4'b0100},
    {16'h0A00, 1'b1, 1'b1, 6'd10, 4'b0000},
    {16'h8A00, 1'b1, 1'b1, 6'd11, 4'b1000},
    {16'h8A00, 1'b0, 1'b1, 6'd11, 4'b0000},
    {16'h0008, 1'b0, 1'b1, 6'd7,  4'b0001},
    {16'h0008, 1'b0, 1'b1, 6'd8,  4'b0000},
    {16'h0088, 1'b0, 1'b1, 6'd7,  4'b0010},
    {16'h0088, 1'b1, 1'b1, 6'd0,  4'b0000},
    {16'h0088, 1'b0, 1'b0, 6'd0,  4'b0000},
    {16'h0088, 1'b0, 1'b1, 6'd0,  4'b0010},
    {16'h1F00, 1'b1, 1'b1, 6'd32, 4'b0100},
    {16'h9F00, 1'b1, 1'b1, 6'd32, 4'b1000},
    {16'h001F, 1'b0, 1'b1, 6'd30, 4'b0001},
    {16'h8F9F, 1'b1, 1'b1, 6'd16, 4'b1000},
    {16'h8F9F, 1'b0, 1'b1, 6'd16, 4'b0010},
    {16'h0000, 1'b1, 1'b0, 6'd5,  4'b0100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rd;
  logic        active = 1'b0;
  logic        dir_rx = 1'b0;
  logic        push = 1'b0;
  logic [15:0] push_data = '0;
  logic        pop = 1'b0;
  logic [15:0] pop_data;
  logic [5:0]  count;
  logic        empty, full, rx_req, tx_req, af_flag, ae_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [15:0] shadow [32];
  bit          written [32];
  int          m_wr = 0, m_rd = 0, m_cnt = 0;
  logic [15:0] seq = 16'h1000;

  always #(CLK_HALF) clk = ~clk;

  tfifo_dma u_tfifo_dma (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_we_i      (cfg_we),
    .cfg_wdata_i   (cfg_wdata),
    .cfg_o         (cfg_rd),
    .xfer_active_i (active),
    .dir_rx_i      (dir_rx),
    .push_i        (push),
    .push_data_i   (push_data),
    .pop_i         (pop),
    .pop_data_o    (pop_data),
    .count_o       (count),
    .empty_o       (empty),
    .full_o        (full),
    .rx_dma_req_o  (rx_req),
    .tx_dma_req_o  (tx_req),
    .af_flag_o     (af_flag),
    .ae_flag_o     (ae_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ps, input logic [15:0] pd, input logic pp,
                      input logic cw, input logic [15:0] cd);
    bit pa, qa;
    @(negedge clk);
    push = ps; push_data = pd; pop = pp; cfg_we = cw; cfg_wdata = cd;
    #0.5;
    if (pp && m_cnt != 0)
      chk("R2 head word", {16'h0, pop_data}, {16'h0, shadow[m_rd]});
    if (pp && m_cnt == 0 && written[m_rd])
      chk("R4 empty read shows head", {16'h0, pop_data}, {16'h0, shadow[m_rd]});
    @(posedge clk);
    #1;
    push = 1'b0; pop = 1'b0; cfg_we = 1'b0;
    pa = ps && (m_cnt != 32);
    qa = pp && (m_cnt != 0);
    if (pa) begin
      shadow[m_wr] = pd;
      written[m_wr] = 1'b1;
      m_wr = (m_wr + 1) % 32;
    end
    if (qa) m_rd = (m_rd + 1) % 32;
    m_cnt = m_cnt + int'(pa) - int'(qa);
    chk("R2 count", {26'h0, count}, m_cnt);
  endtask

  task automatic adjust(input int target);
    while (m_cnt < target) begin
      step(1'b1, seq, 1'b0, 1'b0, 16'h0);
      seq = seq + 16'h0003;
    end
    while (m_cnt > target) step(1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
  endtask

  task automatic set_mode(input logic d, input logic a);
    @(negedge clk);
    dir_rx = d;
    active = a;
  endtask

  function automatic logic [31:0] lvl();
    return {28'h0, rx_req, af_flag, tx_req, ae_flag};
  endfunction

  initial begin
    #(CLK_HALF * 2.0 * 150000.0);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) written[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 count", {26'h0, count}, 0);
    chk("R1 empty/full", {30'h0, empty, full}, 32'h2);
    chk("R1 level outputs", lvl(), 0);
    chk("R1 config", {16'h0, cfg_rd}, 32'h1F00);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: layout and reserved bits
    step(1'b0, 16'h0, 1'b0, 1'b1, 16'hFFFF);
    chk("R10 readback all ones", {16'h0, cfg_rd}, 32'h9F9F);
    step(1'b0, 16'h0, 1'b0, 1'b1, 16'h6A65);
    chk("R10 readback mixed", {16'h0, cfg_rd}, 32'h0A05);

    // R6 R7 R8 R9: threshold routing table
    for (int v = 0; v < NVEC; v++) begin
      step(1'b0, 16'h0, 1'b0, 1'b1, VECS[v][27:12]);
      set_mode(VECS[v][11], VECS[v][10]);
      adjust(int'(VECS[v][9:4]));
      step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
      chk($sformatf("R6/R7/R8/R9 vector %0d", v), lvl(), {28'h0, VECS[v][3:0]});
    end

    // R3: full buffer drops a push
    set_mode(1'b1, 1'b1);
    adjust(32);
    chk("R3 full flag", {31'h0, full}, 1);
    step(1'b1, 16'hDEAD, 1'b0, 1'b0, 16'h0);
    chk("R3 count held at 32", {26'h0, count}, 32);
    // R5: pair at full takes only the pop
    step(1'b1, 16'hBEEF, 1'b1, 1'b0, 16'h0);
    chk("R5 pair at full", {26'h0, count}, 31);
    // R5: pair in the middle keeps count
    adjust(5);
    step(1'b1, 16'h5A5A, 1'b1, 1'b0, 16'h0);
    chk("R5 pair mid", {26'h0, count}, 5);
    adjust(0);
    chk("R3 drained in order, empty", {31'h0, empty}, 1);

    // R4: empty pop keeps pointers
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    chk("R4 count stays 0", {26'h0, count}, 0);
    step(1'b1, 16'h7777, 1'b0, 1'b0, 16'h0);
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    // R5: pair at empty takes only the push
    step(1'b1, 16'h4321, 1'b1, 1'b0, 16'h0);
    chk("R5 pair at empty", {26'h0, count}, 1);
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'h0);

    // R11: flag follows the accepting edge
    step(1'b0, 16'h0, 1'b0, 1'b1, 16'h0000);
    set_mode(1'b1, 1'b1);
    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
    chk("R11 before push", lvl(), 0);
    step(1'b1, 16'h1111, 1'b0, 1'b0, 16'h0);
    chk("R11 flag with new count", lvl(), 32'h4);

    // R12: enabling receive DMA moves flag to request
    step(1'b0, 16'h0, 1'b0, 1'b1, 16'h8000);
    chk("R12 request replaces flag", lvl(), 32'h8);
    step(1'b0, 16'h0, 1'b0, 1'b1, 16'h0000);
    chk("R12 flag back without DMA", lvl(), 32'h4);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule